// File: doc/BRIEF.md
# Sample FIFO with Event Status

This block sits between an analog converter and a byte-wide host port. Each conversion result is a 16-bit word. The block stores it in a first-in first-out buffer and reports how full that buffer is, together with three latched events: a sample was lost, a scan ended, and the fill threshold was reached. The host collects one sample with two byte reads from the data address, low byte first. Writes to the same address set the fill threshold. The threshold is given as the number of free bytes that may remain when the threshold event fires, not as a fill level.

The sample input carries a valid strobe and no ready. The converter cannot be stalled, so the block applies no back-pressure. A sample that arrives while the buffer is full is discarded and recorded as lost. Reading the status byte returns the flags and then clears the three events. The interrupt output is the OR of the enabled end-of-scan and threshold events. A self-clearing flush command empties the buffer.

Top module: `sfifo_evstat`

## Requirements
- R1: Every cycle with `in_valid` high stores `in_data` as one sample, provided the buffer holds fewer than `SAMPLES` samples and no flush is being written in that cycle. There is no ready signal.
- R2: A read at address 0 returns the low byte of the oldest sample. The next read at address 0 returns its high byte and removes the sample. A read at address 0 while the buffer is empty returns 0x00 and changes no state. Read data appears on `host_rdata` one cycle after the read strobe.
- R3: A sample that arrives while the buffer holds `SAMPLES` samples is discarded, stored data stays unchanged, and data-lost (status bit 5) is set.
- R4: The status byte at address 1 has this layout: bit 7 idle, bit 6 running, bit 5 data lost, bit 4 end of scan, bit 3 threshold event, bit 2 full, bit 1 near-full, bit 0 empty.
- R5: Near-full (bit 1) is high while the free bytes, 2*(SAMPLES-count), are at or below the near-full threshold. An accepted sample sets the threshold event (bit 3) when the free bytes after storing it are at or below the threshold. A read in the same cycle is not counted.
- R6: Four byte writes to address 0 program the thresholds in this order: near-empty low, near-empty high, near-full low, near-full high. The near-empty bytes are discarded. The new near-full value takes effect on the fourth write, and then the sequence starts again. After reset the near-full threshold is `SAMPLES` bytes.
- R7: A sample with `in_eos` high sets end of scan (bit 4), even if the sample itself is dropped.
- R8: A status read returns the flags as they stood before the read, then clears bits 5, 4 and 3. An event that is raised in the same cycle as the read stays set.
- R9: A write to address 1 sets the interrupt enables: bit 4 enables end of scan and bit 3 enables the threshold event. `irq` is the OR of the enabled latched events and falls once a status read clears them. Data lost never raises `irq`.
- R10: A write to address 2 with bit 0 set empties the buffer and restarts both the read byte order and the threshold write sequence. It leaves the events and the threshold value unchanged. A sample arriving in that same cycle is discarded without setting data lost. A write to address 2 with bit 0 clear has no effect.
- R11: Running (bit 6) follows `acq_active`, and idle (bit 7) is its inverse.
- R12: After reset the buffer is empty, all events are clear, both enables are off, `irq` is low, and the status reads 0x81 while `acq_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A conversion result is present this cycle |
| in_data | input | 16 | Conversion result |
| in_eos | input | 1 | This result is the last one of a scan |
| acq_active | input | 1 | Acquisition is running |
| host_rd | input | 1 | Host byte read strobe |
| host_wr | input | 1 | Host byte write strobe |
| host_addr | input | 2 | 0 data/threshold, 1 status/control, 2 command |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid one cycle after the strobe |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check four things:
- the occupancy never exceeds capacity;
- a sample offered to a full buffer leaves the occupancy unchanged;
- a flush always leaves the buffer empty;
- a status read without a competing event clears the latched events and drops `irq`.

The byte ordering of samples, the free-byte meaning of the threshold, the realignment of the threshold write sequence after a flush, and a status read racing a new event can only be shown by the bench's scenarios, which drive the host port and compare what comes back.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int ST_IDLE  = 7;
  localparam int ST_RUN   = 6;
  localparam int ST_LOST  = 5;
  localparam int ST_EOS   = 4;
  localparam int ST_THR   = 3;
  localparam int ST_FULL  = 2;
  localparam int ST_NFULL = 1;
  localparam int ST_EMPTY = 0;

  localparam int CTL_EOS_IE = 4;
  localparam int CTL_THR_IE = 3;
  localparam int CMD_FLUSH  = 0;

  typedef enum logic [1:0] {
    A_DATA = 2'd0,
    A_STAT = 2'd1,
    A_CMD  = 2'd2,
    A_NONE = 2'd3
  } haddr_e;
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int SAMPLES = 2048,
  parameter int DW      = 16,
  localparam int AW     = $clog2(SAMPLES),
  localparam int CW     = $clog2(SAMPLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok
);
  logic [DW-1:0] mem [SAMPLES];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop_ok;

  assign full    = (count == CW'(SAMPLES));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head_data = mem[rd_ptr];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(SAMPLES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(SAMPLES));

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (count == $past(count)));

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/sfifo_hostif.sv
module sfifo_hostif #(
  parameter int SAMPLES = 2048,
  localparam int BYTES  = 2 * SAMPLES
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        rd_data,
  input  logic        wr_data,
  input  logic [7:0]  wdata,
  input  logic        empty,
  input  logic [15:0] head_data,
  output logic        pop,
  output logic [7:0]  rd_byte,
  output logic [15:0] nf_thr
);
  logic       hi_phase;
  logic [1:0] wseq;
  logic [7:0] lo_stage;

  assign rd_byte = empty ? 8'h00 : (hi_phase ? head_data[15:8] : head_data[7:0]);
  assign pop     = rd_data && hi_phase && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_phase <= 1'b0;
      wseq     <= 2'd0;
      lo_stage <= 8'h00;
      nf_thr   <= 16'(BYTES / 2);
    end else if (flush) begin
      hi_phase <= 1'b0;
      wseq     <= 2'd0;
    end else begin
      if (rd_data && !empty) hi_phase <= !hi_phase;
      if (wr_data) begin
        wseq <= wseq + 2'd1;
        if (wseq == 2'd2) lo_stage <= wdata;
        if (wseq == 2'd3) nf_thr   <= {wdata, lo_stage};
      end
    end
  end

  assert_empty_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && empty && !flush) |=> $stable(hi_phase));
endmodule

// File: rtl/sfifo_events.sv
module sfifo_events (
  input  logic clk,
  input  logic rst_n,
  input  logic set_lost,
  input  logic set_eos,
  input  logic set_thr,
  input  logic clr,
  input  logic eos_ie,
  input  logic thr_ie,
  output logic ev_lost,
  output logic ev_eos,
  output logic ev_thr,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_lost <= 1'b0;
      ev_eos  <= 1'b0;
      ev_thr  <= 1'b0;
    end else begin
      ev_lost <= set_lost | (ev_lost & ~clr);
      ev_eos  <= set_eos  | (ev_eos  & ~clr);
      ev_thr  <= set_thr  | (ev_thr  & ~clr);
    end
  end

  assign irq = (ev_eos & eos_ie) | (ev_thr & thr_ie);

  assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_lost && !set_eos && !set_thr) |=> (!ev_lost && !ev_eos && !ev_thr));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_eos |=> ev_eos);

  assert_irq_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_eos && !set_thr) |=> !irq);
endmodule

// File: rtl/sfifo_evstat.sv
module sfifo_evstat
  import sfifo_pkg::*;
#(
  parameter int SAMPLES = 2048,
  localparam int BYTES  = 2 * SAMPLES,
  localparam int CW     = $clog2(SAMPLES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_data,
  input  logic        in_eos,
  input  logic        acq_active,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [1:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        irq
);
  haddr_e        addr;
  logic          flush, rd_data, wr_data, rd_stat, wr_ctl;
  logic          pop, push_ok, full, empty;
  logic [15:0]   head_data, nf_thr;
  logic [CW-1:0] count;
  logic [7:0]    rd_byte, status;
  logic [31:0]   free_b;
  logic          near_full, set_thr;
  logic          ev_lost, ev_eos, ev_thr;
  logic          eos_ie, thr_ie;

  assign addr    = haddr_e'(host_addr);
  assign flush   = host_wr && (addr == A_CMD) && host_wdata[CMD_FLUSH];
  assign rd_data = host_rd && (addr == A_DATA);
  assign wr_data = host_wr && (addr == A_DATA);
  assign rd_stat = host_rd && (addr == A_STAT);
  assign wr_ctl  = host_wr && (addr == A_STAT);

  sfifo_store #(.SAMPLES(SAMPLES), .DW(16)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(in_valid), .push_data(in_data), .pop(pop),
    .head_data(head_data), .count(count), .full(full), .empty(empty),
    .push_ok(push_ok)
  );

  sfifo_hostif #(.SAMPLES(SAMPLES)) u_hostif (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rd_data(rd_data), .wr_data(wr_data), .wdata(host_wdata),
    .empty(empty), .head_data(head_data),
    .pop(pop), .rd_byte(rd_byte), .nf_thr(nf_thr)
  );

  assign free_b    = 32'(BYTES) - (32'(count) << 1);
  assign near_full = free_b <= {16'h0, nf_thr};
  assign set_thr   = push_ok && ((free_b - 32'd2) <= {16'h0, nf_thr});

  sfifo_events u_events (
    .clk(clk), .rst_n(rst_n),
    .set_lost(in_valid && full && !flush),
    .set_eos(in_valid && in_eos),
    .set_thr(set_thr),
    .clr(rd_stat),
    .eos_ie(eos_ie), .thr_ie(thr_ie),
    .ev_lost(ev_lost), .ev_eos(ev_eos), .ev_thr(ev_thr), .irq(irq)
  );

  always_comb begin
    status           = '0;
    status[ST_IDLE]  = !acq_active;
    status[ST_RUN]   = acq_active;
    status[ST_LOST]  = ev_lost;
    status[ST_EOS]   = ev_eos;
    status[ST_THR]   = ev_thr;
    status[ST_FULL]  = full;
    status[ST_NFULL] = near_full;
    status[ST_EMPTY] = empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eos_ie     <= 1'b0;
      thr_ie     <= 1'b0;
      host_rdata <= 8'h00;
    end else begin
      if (wr_ctl) begin
        eos_ie <= host_wdata[CTL_EOS_IE];
        thr_ie <= host_wdata[CTL_THR_IE];
      end
      if (host_rd) begin
        case (addr)
          A_DATA:  host_rdata <= rd_byte;
          A_STAT:  host_rdata <= status;
          default: host_rdata <= 8'h00;
        endcase
      end
    end
  end

  assert_lost_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !flush) |=> ev_lost);
endmodule

// File: tb/sfifo_evstat_tb.sv
module sfifo_evstat_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_eos = 0, acq_active = 0;
  logic [15:0] in_data = '0;
  logic host_rd = 0, host_wr = 0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfifo_evstat #(.SAMPLES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_eos(in_eos), .acq_active(acq_active), .host_rd(host_rd),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic push(input logic [15:0] d, input logic e);
    @(negedge clk); in_valid = 1; in_data = d; in_eos = e;
    @(negedge clk); in_valid = 0; in_eos = 0;
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  task automatic stat_is(input string req, input int exp);
    logic [7:0] s;
    hread(2'd1, s);
    check(req, s, exp);
  endtask

  task automatic set_thr(input logic [15:0] t);
    hwrite(2'd0, 8'h00); hwrite(2'd0, 8'h00);
    hwrite(2'd0, t[7:0]); hwrite(2'd0, t[15:8]);
  endtask

  task automatic t_reset;
    check("R12 irq", irq, 0);
    stat_is("R12 status", 8'h81);
  endtask

  task automatic t_order;
    logic [7:0] b;
    push(16'h1234, 0); push(16'hABCD, 0);
    hread(2'd0, b); check("R2 lo0", b, 8'h34);
    hread(2'd0, b); check("R2 hi0", b, 8'h12);
    hread(2'd0, b); check("R2 lo1", b, 8'hCD);
    hread(2'd0, b); check("R2 hi1", b, 8'hAB);
    hread(2'd0, b); check("R2 empty", b, 8'h00);
    stat_is("R1 R4 empty again", 8'h81);
  endtask

  task automatic t_nearfull;
    set_thr(16'd8);
    for (int i = 0; i < 11; i++) push(16'(i), 0);
    stat_is("R5 below", 8'h80);
    push(16'h00FF, 0);
    stat_is("R5 reached", 8'h8A);
    stat_is("R8 cleared R5 level", 8'h82);
    hwrite(2'd2, 8'h01);
    stat_is("R10 flushed", 8'h81);
  endtask

  task automatic t_full;
    logic [7:0] b;
    for (int i = 0; i < N; i++) push(16'h0100 + 16'(i), 0);
    stat_is("R3 full", 8'h8E);
    stat_is("R8 clear", 8'h86);
    push(16'hDEAD, 0);
    check("R9 lost no irq", irq, 0);
    stat_is("R3 lost", 8'hA6);
    stat_is("R8 lost cleared", 8'h86);
    hread(2'd0, b); check("R3 head lo", b, 8'h00);
    hread(2'd0, b); check("R3 head hi", b, 8'h01);
    hwrite(2'd2, 8'h01);
  endtask

  task automatic t_eos_irq;
    hwrite(2'd1, 8'h10);
    push(16'h5555, 1);
    check("R9 eos irq", irq, 1);
    stat_is("R7 eos", 8'h90);
    check("R9 irq cleared", irq, 0);
    hwrite(2'd1, 8'h08);
    push(16'h6666, 1);
    check("R9 eos masked", irq, 0);
    stat_is("R7 eos2", 8'h90);
    hwrite(2'd1, 8'h00);
    hwrite(2'd2, 8'h01);
  endtask

  task automatic t_same_cycle;
    @(negedge clk); host_rd = 1; host_addr = 2'd1; in_valid = 1; in_eos = 1; in_data = 16'h7777;
    @(negedge clk); host_rd = 0; in_valid = 0; in_eos = 0;
    check("R8 pre-clear value", host_rdata, 8'h81);
    stat_is("R8 set wins", 8'h90);
    hwrite(2'd2, 8'h01);
  endtask

  task automatic t_flush;
    push(16'h1111, 0);
    hwrite(2'd2, 8'hFE);
    stat_is("R10 no flush", 8'h80);
    hwrite(2'd2, 8'h01);
    stat_is("R10 flush", 8'h81);
    @(negedge clk); host_wr = 1; host_addr = 2'd2; host_wdata = 8'h01; in_valid = 1; in_data = 16'h2222;
    @(negedge clk); host_wr = 0; in_valid = 0;
    stat_is("R10 same-cycle drop", 8'h81);
  endtask

  task automatic t_running;
    acq_active = 1;
    stat_is("R11 running", 8'h41);
    acq_active = 0;
  endtask

  task automatic t_seq_restart;
    hwrite(2'd0, 8'hFF);
    hwrite(2'd2, 8'h01);
    set_thr(16'd30);
    hwrite(2'd1, 8'h08);
    push(16'h3333, 0);
    check("R6 R9 thr irq", irq, 1);
    stat_is("R6 thr 30", 8'h8A);
    check("R9 thr irq cleared", irq, 0);
    hwrite(2'd1, 8'h00);
    hwrite(2'd2, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_order();
    t_nearfull();
    t_full();
    t_eos_irq();
    t_same_cycle();
    t_flush();
    t_running();
    t_seq_restart();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog got=0x0 exp=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule